// File: doc/BRIEF.md
# Dual-Port Subscriber Line Controller

This block is the digital supervisor for a two-port telephone line interface. It drives five parallel control pins: three mode bits and two port-select bits. It reads three active-low detector outputs, one combined and one for each port. While idle it holds both ports in high-impedance feed and watches the per-port detectors. When a handset lifts, it moves the answering port to active feed in normal polarity.

On a host ring request it runs a ring cadence on port 1, port 2 or both. Each burst puts the interface in ring mode and toggles the polarity bit to produce the ring waveform. Each pause returns to high-impedance monitoring. A ring trip first freezes the polarity bit, then connects the answering port. If both ports were rung, the answering port is found by selecting one port at a time in active mode and reading the combined detector.

A call ends when the combined detector has reported on-hook for a full persistence window, or when the host requests a hang-up. All control pins are held low while the supply-good input is deasserted.

Top module: `dpline_ctrl`

## Requirements
- R1: While `supply_ok` is low, all of `ctl_d` and `ctl_p` read 0 (power down) one clock later. When `supply_ok` is high and the line is idle, the block sits in MONITOR with `ctl_d`=000 and `ctl_p`=11. Pin packing is `ctl_d[0]`=D0, `ctl_d[1]`=D1, `ctl_d[2]`=D2, `ctl_p[0]`=port 1 select, `ctl_p[1]`=port 2 select.
- R2: In MONITOR, a filtered low on `det1_n` or `det2_n` moves the block to ACTIVE: `ctl_d`=010 (active, normal polarity) with only the answering port's select bit set. Port 1 wins when both ports report together.
- R3: A `ring_go` pulse in MONITOR with `ring_ports` nonzero starts ringing. `ring_ports[0]` selects port 1 and `ring_ports[1]` selects port 2. The block alternates BURST (`ctl_d[1:0]`=01, `ctl_p`=requested ports) for BURST_MS ticks with PAUSE (`ctl_d`=000, `ctl_p`=11) for PAUSE_MS ticks.
- R4: During BURST, D2 starts at 0 and inverts every RING_HALF_MS ticks of `ms_tick`, so a burst shows (BURST_MS/RING_HALF_MS)-1 transitions. Outside ring mode, D2 is 0 whenever D0 and D1 are both 0.
- R5: A filtered low on `det_n` during BURST moves the block to TRIP on the next clock. TRIP holds ring mode with D2=0 until the next tick. A single rung port then goes to ACTIVE on that port.
- R6: After a trip with both ports rung, PROBE_A selects port 2 only (`ctl_p`=10) in active mode for PROBE_MS ticks. If `det_n` is low, port 2 goes ACTIVE. Otherwise PROBE_B selects port 1 only (`ctl_p`=01) for PROBE_MS ticks. If `det_n` is low, port 1 goes ACTIVE; if not, the block returns to MONITOR.
- R7: During PAUSE, a filtered low on `det1_n` or `det2_n` goes directly to ACTIVE on that port, with port 1 taking precedence.
- R8: ACTIVE returns to MONITOR only after `det_n` has been filtered high for ONHOOK_MS consecutive ticks. A shorter high interval leaves the block in ACTIVE.
- R9: A `hangup` pulse in BURST, PAUSE, TRIP, PROBE_A, PROBE_B or ACTIVE returns the block to MONITOR, and ringing does not resume.
- R10: A detector input is taken into account only after it has held a new level for DEB_LEN clocks after its two-flop synchroniser. Shorter pulses have no effect.
- R11: `ring_go` is ignored outside MONITOR, and also ignored when `ring_ports` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-good indication; low forces power down |
| ms_tick | input | 1 | One-clock pulse each millisecond |
| ring_go | input | 1 | Host pulse requesting ringing |
| ring_ports | input | 2 | Ports to ring, bit 0 = port 1, bit 1 = port 2 |
| hangup | input | 1 | Host pulse forcing return to monitoring |
| det_n | input | 1 | Combined hook/trip detector, active low |
| det1_n | input | 1 | Port 1 detector (valid in high-impedance feed), active low |
| det2_n | input | 1 | Port 2 detector (valid in high-impedance feed), active low |
| ctl_d | output | 3 | Mode pins D0 (bit 0), D1 (bit 1), D2 (bit 2) |
| ctl_p | output | 2 | Port selects, bit 0 = port 1, bit 1 = port 2 |

## Verification
The bench models the line itself, so each detector answers according to the mode and port selects the block is currently driving.

- **Probe order.** The dual-rung answer is tried from each side. A wrong probe order, or a wrong pin choice during probing, connects the silent port instead of the answering one.
- **Ring cadence.** The bench counts D2 transitions inside one burst. A divider that is off by one tick, or one that keeps running into the pause, changes the count.
- **On-hook persistence.** Short hook flashes are applied and must not drop the call. A missing timer reset ends calls early.
- **Filtering and request gating.** Brief detector glitches, ring requests during a call and a hang-up in mid-burst are applied. Weak filtering or request gating shows up as a spurious port change or as ringing that resumes.

// File: rtl/dpl_pkg.sv
package dpl_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_MONITOR,
        ST_BURST,
        ST_PAUSE,
        ST_TRIP,
        ST_PROBE_A,
        ST_PROBE_B,
        ST_ACTIVE
    } dpl_state_e;

    // mode pin patterns, bit0 = D0, bit1 = D1, bit2 = D2
    localparam logic [2:0] MODE_OFF    = 3'b000;
    localparam logic [2:0] MODE_ACT_NP = 3'b010;
    localparam logic [2:0] MODE_RING   = 3'b001;

    localparam logic [1:0] SEL_NONE  = 2'b00;
    localparam logic [1:0] SEL_PORT1 = 2'b01;
    localparam logic [1:0] SEL_PORT2 = 2'b10;
    localparam logic [1:0] SEL_BOTH  = 2'b11;

endpackage

// File: rtl/det_filter.sv
module det_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_LEN     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_n,
    output logic filt_n
);
    localparam int CW = (DEB_LEN > 1) ? $clog2(DEB_LEN) : 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_cnt;
    logic                   sync_out;

    assign sync_out = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q[0] <= raw_n;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_n  <= 1'b1;
            run_cnt <= '0;
        end else if (sync_out == filt_n) begin
            run_cnt <= '0;
        end else if (run_cnt == CW'(DEB_LEN - 1)) begin
            filt_n  <= sync_out;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R10
    deb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_n != $past(filt_n)) |-> ($past(sync_out) == filt_n));

endmodule

// File: rtl/ring_toggle.sv
module ring_toggle #(
    parameter int RING_HALF_MS = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    output logic pol
);
    localparam int HW = (RING_HALF_MS > 1) ? $clog2(RING_HALF_MS) : 1;

    logic [HW-1:0] half_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_cnt <= '0;
            pol      <= 1'b0;
        end else if (!en) begin
            half_cnt <= '0;
            pol      <= 1'b0;
        end else if (tick) begin
            if (half_cnt == HW'(RING_HALF_MS - 1)) begin
                half_cnt <= '0;
                pol      <= ~pol;
            end else begin
                half_cnt <= half_cnt + 1'b1;
            end
        end
    end

    // R4
    ring_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && (pol != $past(pol))) |-> $past(tick));

endmodule

// File: rtl/hook_fsm.sv
module hook_fsm
    import dpl_pkg::*;
#(
    parameter int BURST_MS  = 1000,
    parameter int PAUSE_MS  = 4000,
    parameter int ONHOOK_MS = 300,
    parameter int PROBE_MS  = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       ms_tick,
    input  logic       ring_go,
    input  logic [1:0] ring_ports,
    input  logic       hangup,
    input  logic       det_f,
    input  logic       det1_f,
    input  logic       det2_f,
    input  logic       ring_pol,
    output logic       ring_en,
    output logic [2:0] ctl_d,
    output logic [1:0] ctl_p
);
    localparam int MAX_A  = (BURST_MS > PAUSE_MS) ? BURST_MS : PAUSE_MS;
    localparam int MAX_B  = (ONHOOK_MS > PROBE_MS) ? ONHOOK_MS : PROBE_MS;
    localparam int MAX_MS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW     = $clog2(MAX_MS + 1);

    dpl_state_e    state, nxt;
    logic [TW-1:0] timer;
    logic [1:0]    ring_q, act_port, nxt_port;
    logic          burst_end, pause_end, probe_end, onhook_end;

    assign burst_end  = ms_tick && (timer == TW'(BURST_MS - 1));
    assign pause_end  = ms_tick && (timer == TW'(PAUSE_MS - 1));
    assign probe_end  = ms_tick && (timer == TW'(PROBE_MS - 1));
    assign onhook_end = ms_tick && det_f && (timer == TW'(ONHOOK_MS - 1));

    // next-state decision
    always_comb begin
        nxt      = state;
        nxt_port = act_port;
        if (!supply_ok) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF: nxt = ST_MONITOR;
                ST_MONITOR: begin
                    if (!det1_f) begin
                        nxt = ST_ACTIVE; nxt_port = SEL_PORT1;
                    end else if (!det2_f) begin
                        nxt = ST_ACTIVE; nxt_port = SEL_PORT2;
                    end else if (ring_go && (ring_ports != SEL_NONE)) begin
                        nxt = ST_BURST;
                    end
                end
                ST_BURST: begin
                    if (hangup)          nxt = ST_MONITOR;
                    else if (!det_f)     nxt = ST_TRIP;
                    else if (burst_end)  nxt = ST_PAUSE;
                end
                ST_PAUSE: begin
                    if (hangup) begin
                        nxt = ST_MONITOR;
                    end else if (!det1_f) begin
                        nxt = ST_ACTIVE; nxt_port = SEL_PORT1;
                    end else if (!det2_f) begin
                        nxt = ST_ACTIVE; nxt_port = SEL_PORT2;
                    end else if (pause_end) begin
                        nxt = ST_BURST;
                    end
                end
                ST_TRIP: begin
                    if (hangup) begin
                        nxt = ST_MONITOR;
                    end else if (ms_tick) begin
                        if (ring_q == SEL_BOTH) begin
                            nxt = ST_PROBE_A;
                        end else begin
                            nxt = ST_ACTIVE; nxt_port = ring_q;
                        end
                    end
                end
                ST_PROBE_A: begin
                    if (hangup) begin
                        nxt = ST_MONITOR;
                    end else if (probe_end) begin
                        if (!det_f) begin
                            nxt = ST_ACTIVE; nxt_port = SEL_PORT2;
                        end else begin
                            nxt = ST_PROBE_B;
                        end
                    end
                end
                ST_PROBE_B: begin
                    if (hangup) begin
                        nxt = ST_MONITOR;
                    end else if (probe_end) begin
                        if (!det_f) begin
                            nxt = ST_ACTIVE; nxt_port = SEL_PORT1;
                        end else begin
                            nxt = ST_MONITOR;
                        end
                    end
                end
                ST_ACTIVE: begin
                    if (hangup || onhook_end) nxt = ST_MONITOR;
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_OFF;
            act_port <= SEL_NONE;
            ring_q   <= SEL_NONE;
        end else begin
            state    <= nxt;
            act_port <= nxt_port;
            if (state == ST_MONITOR && nxt == ST_BURST) begin
                ring_q <= ring_ports;
            end
        end
    end

    // dwell timer in ms ticks, cleared on every state change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer <= '0;
        end else if (nxt != state) begin
            timer <= '0;
        end else if (state == ST_ACTIVE && !det_f) begin
            timer <= '0;
        end else if (ms_tick) begin
            timer <= timer + 1'b1;
        end
    end

    // pin outputs
    always_comb begin
        ring_en = 1'b0;
        ctl_d   = MODE_OFF;
        ctl_p   = SEL_NONE;
        unique case (state)
            ST_OFF: begin
                ctl_d = MODE_OFF;
                ctl_p = SEL_NONE;
            end
            ST_MONITOR, ST_PAUSE: begin
                ctl_d = MODE_OFF;
                ctl_p = SEL_BOTH;
            end
            ST_BURST: begin
                ring_en = 1'b1;
                ctl_d   = {ring_pol, MODE_RING[1:0]};
                ctl_p   = ring_q;
            end
            ST_TRIP: begin
                ctl_d = MODE_RING;
                ctl_p = ring_q;
            end
            ST_PROBE_A: begin
                ctl_d = MODE_ACT_NP;
                ctl_p = SEL_PORT2;
            end
            ST_PROBE_B: begin
                ctl_d = MODE_ACT_NP;
                ctl_p = SEL_PORT1;
            end
            ST_ACTIVE: begin
                ctl_d = MODE_ACT_NP;
                ctl_p = act_port;
            end
            default: begin
                ctl_d = MODE_OFF;
                ctl_p = SEL_NONE;
            end
        endcase
    end

    // R1
    pwr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (ctl_d == 3'b000 && ctl_p == 2'b00));

    // R2
    act_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_d[1] && !ctl_d[0]) |-> ($countones(ctl_p) == 1));

    // R4
    d2_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_d[1:0] == 2'b00) |-> !ctl_d[2]);

    // R5
    trip_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST && !det_f && supply_ok && !hangup) |=> (ctl_d == 3'b001));

    // R8
    onhook_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && !det_f && supply_ok && !hangup) |=> (state == ST_ACTIVE));

endmodule

// File: rtl/dpline_ctrl.sv
module dpline_ctrl #(
    parameter int DEB_LEN      = 4,
    parameter int RING_HALF_MS = 25,
    parameter int BURST_MS     = 1000,
    parameter int PAUSE_MS     = 4000,
    parameter int ONHOOK_MS    = 300,
    parameter int PROBE_MS     = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       ms_tick,
    input  logic       ring_go,
    input  logic [1:0] ring_ports,
    input  logic       hangup,
    input  logic       det_n,
    input  logic       det1_n,
    input  logic       det2_n,
    output logic [2:0] ctl_d,
    output logic [1:0] ctl_p
);
    localparam int NDET = 3;

    logic [NDET-1:0] det_raw, det_flt;
    logic            ring_en, ring_pol;

    assign det_raw = {det2_n, det1_n, det_n};

    for (genvar g = 0; g < NDET; g++) begin : g_det
        det_filter #(
            .SYNC_STAGES(2),
            .DEB_LEN    (DEB_LEN)
        ) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_n (det_raw[g]),
            .filt_n(det_flt[g])
        );
    end

    ring_toggle #(
        .RING_HALF_MS(RING_HALF_MS)
    ) u_ring (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (ring_en),
        .tick (ms_tick),
        .pol  (ring_pol)
    );

    hook_fsm #(
        .BURST_MS (BURST_MS),
        .PAUSE_MS (PAUSE_MS),
        .ONHOOK_MS(ONHOOK_MS),
        .PROBE_MS (PROBE_MS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .ms_tick   (ms_tick),
        .ring_go   (ring_go),
        .ring_ports(ring_ports),
        .hangup    (hangup),
        .det_f     (det_flt[0]),
        .det1_f    (det_flt[1]),
        .det2_f    (det_flt[2]),
        .ring_pol  (ring_pol),
        .ring_en   (ring_en),
        .ctl_d     (ctl_d),
        .ctl_p     (ctl_p)
    );

endmodule

// File: tb/dpline_ctrl_test.sv
`timescale 1ns/1ps
module dpline_ctrl_test;

    localparam int HALF = 2;
    localparam int BUR  = 8;
    localparam int PAU  = 6;
    localparam int ONH  = 10;
    localparam int PRB  = 4;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       supply_ok = 0;
    logic       ms_tick = 0;
    logic       ring_go = 0;
    logic [1:0] ring_ports = 0;
    logic       hangup = 0;
    logic       hook1 = 0, hook2 = 0, glitch1 = 0;
    logic       det_n, det1_n, det2_n;
    logic [2:0] ctl_d;
    logic [1:0] ctl_p;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    // line model: detectors respond to the pins the block drives
    logic hiz;
    assign hiz    = !ctl_d[0] && !ctl_d[1];
    assign det1_n = hiz ? !(ctl_p[0] && hook1) && !glitch1 : 1'b1;
    assign det2_n = hiz ? !(ctl_p[1] && hook2) : 1'b1;
    assign det_n  = hiz ? (det1_n && det2_n)
                        : !((ctl_p[0] && hook1) || (ctl_p[1] && hook2));

    dpline_ctrl #(
        .DEB_LEN(4), .RING_HALF_MS(HALF), .BURST_MS(BUR),
        .PAUSE_MS(PAU), .ONHOOK_MS(ONH), .PROBE_MS(PRB)
    ) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ms_tick(ms_tick),
        .ring_go(ring_go), .ring_ports(ring_ports), .hangup(hangup),
        .det_n(det_n), .det1_n(det1_n), .det2_n(det2_n),
        .ctl_d(ctl_d), .ctl_p(ctl_p)
    );

    initial begin
        forever begin
            repeat (3) @(negedge clk) ms_tick = 0;
            @(negedge clk) ms_tick = 1;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_pins(input string req, input logic [2:0] ed, input logic [1:0] ep);
        checks++;
        if (ctl_d !== ed || ctl_p !== ep) begin
            errors++;
            $display("FAIL %s: d=%b p=%b expected d=%b p=%b", req, ctl_d, ctl_p, ed, ep);
        end
    endtask

    task automatic pulse_ring(input logic [1:0] ports);
        ring_ports = ports;
        ring_go = 1;
        @(negedge clk);
        ring_go = 0;
    endtask

    task automatic pulse_hangup();
        hangup = 1;
        @(negedge clk);
        hangup = 0;
    endtask

    task automatic t_supply_on();
        wait_cyc(5);
        rst_n = 1;
        wait_cyc(5);
        check_pins("R1 held low", 3'b000, 2'b00);
        supply_ok = 1;
        wait_cyc(3);
        check_pins("R1 monitor", 3'b000, 2'b11);
    endtask

    task automatic t_glitch();
        glitch1 = 1;
        wait_cyc(2);
        glitch1 = 0;
        wait_cyc(20);
        check_pins("R10 glitch ignored", 3'b000, 2'b11);
    endtask

    task automatic t_answer_and_onhook();
        hook2 = 1;
        wait_cyc(20);
        check_pins("R2 port2 answer", 3'b010, 2'b10);
        hook2 = 0;
        wait_cyc(20);
        hook2 = 1;
        wait_cyc(30);
        check_pins("R8 flash kept", 3'b010, 2'b10);
        hook2 = 0;
        wait_cyc(30);
        check_pins("R8 before timeout", 3'b010, 2'b10);
        wait_cyc(40);
        check_pins("R8 after timeout", 3'b000, 2'b11);
    endtask

    task automatic t_both_offhook();
        hook1 = 1; hook2 = 1;
        wait_cyc(20);
        check_pins("R2 port1 precedence", 3'b010, 2'b01);
        hook1 = 0; hook2 = 0;
        wait_cyc(80);
        check_pins("R8 back to monitor", 3'b000, 2'b11);
    endtask

    task automatic t_zero_ring();
        pulse_ring(2'b00);
        wait_cyc(20);
        check_pins("R11 empty ring ignored", 3'b000, 2'b11);
    endtask

    task automatic t_ring_port1();
        logic prev;
        int   toggles;
        int   guard;
        pulse_ring(2'b01);
        check_pins("R3 burst port1", 3'b001, 2'b01);
        prev = ctl_d[2];
        toggles = 0;
        guard = 0;
        while (ctl_d[1:0] == 2'b01 && guard < 200) begin
            @(negedge clk);
            guard++;
            if (ctl_d[1:0] == 2'b01 && ctl_d[2] != prev) toggles++;
            prev = ctl_d[2];
        end
        checks++;
        if (toggles != (BUR / HALF) - 1) begin
            errors++;
            $display("FAIL R4 toggles: got %0d expected %0d", toggles, (BUR / HALF) - 1);
        end
        check_pins("R3 R4 pause", 3'b000, 2'b11);
        guard = 0;
        while (ctl_d[0] != 1'b1 && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        wait_cyc(1);
        checks++;
        if (ctl_d[1:0] !== 2'b01 || ctl_p !== 2'b01) begin
            errors++;
            $display("FAIL R3 second burst: d=%b p=%b expected d=x01 p=01", ctl_d, ctl_p);
        end
        hook1 = 1;
        wait_cyc(30);
        check_pins("R5 trip to active", 3'b010, 2'b01);
        hook1 = 0;
        wait_cyc(80);
        check_pins("R8 monitor after trip call", 3'b000, 2'b11);
    endtask

    task automatic t_ring_both(input int answer);
        pulse_ring(2'b11);
        wait_cyc(2);
        checks++;
        if (ctl_d[1:0] !== 2'b01 || ctl_p !== 2'b11) begin
            errors++;
            $display("FAIL R3 both burst: d=%b p=%b expected d=x01 p=11", ctl_d, ctl_p);
        end
        if (answer == 2) hook2 = 1; else hook1 = 1;
        wait_cyc(90);
        if (answer == 2) check_pins("R6 probe finds port2", 3'b010, 2'b10);
        else             check_pins("R6 probe finds port1", 3'b010, 2'b01);
        hook1 = 0; hook2 = 0;
        wait_cyc(80);
        check_pins("R8 monitor after probe call", 3'b000, 2'b11);
    endtask

    task automatic t_pause_answer();
        int guard;
        pulse_ring(2'b10);
        guard = 0;
        while (ctl_d[0] == 1'b1 && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        check_pins("R3 pause after burst", 3'b000, 2'b11);
        hook2 = 1;
        wait_cyc(15);
        check_pins("R7 pause answer", 3'b010, 2'b10);
        pulse_ring(2'b11);
        wait_cyc(20);
        check_pins("R11 ring while active", 3'b010, 2'b10);
        hook2 = 0;
        wait_cyc(80);
        check_pins("R8 monitor after pause call", 3'b000, 2'b11);
    endtask

    task automatic t_hangup();
        pulse_ring(2'b11);
        wait_cyc(2);
        pulse_hangup();
        wait_cyc(2);
        check_pins("R9 hangup stops ring", 3'b000, 2'b11);
        wait_cyc(100);
        check_pins("R9 ring not resumed", 3'b000, 2'b11);
    endtask

    task automatic t_supply_drop();
        hook1 = 1;
        wait_cyc(20);
        check_pins("R2 port1 answer", 3'b010, 2'b01);
        supply_ok = 0;
        wait_cyc(3);
        check_pins("R1 supply drop", 3'b000, 2'b00);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(50000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        t_supply_on();
        t_glitch();
        t_answer_and_onhook();
        t_both_offhook();
        t_zero_ring();
        t_ring_port1();
        t_ring_both(2);
        t_ring_both(1);
        t_pause_answer();
        t_hangup();
        t_supply_drop();
        finish_run();
    end

endmodule